// File: doc/BRIEF.md
# Lock-Aware Victim Way Selector

This block picks the way to evict when a set-associative cache misses, and it applies line-lock requests, honouring a lock bit per way. The cache presents, for the index being accessed, the current lock bits and the requester's availability mask, which marks the ways that requester is allowed to use. The block answers in the same cycle with the victim way, the new lock vector for the index and a write strobe for it. Among the free ways (available and unlocked), a round-robin pointer sets the order in which victims are taken.

The block never locks the last free way a requester has at an index. Such a lock request is dropped, the access itself goes ahead, and a sticky lock-refused flag is raised. If a miss finds no free way at all, the block takes the lowest-numbered way in the mask as victim, clears that way's lock bit and raises a second sticky flag. Each flag has its own interrupt enable and its own write-1 clear. The tag and data arrays belong to the surrounding cache.

Top module: `way_victim_lock_sel`

## Requirements
- R1: On a miss (reqValid=1, reqMiss=1) where the free set (availMask & ~lockBits) is non-empty, victimWay is a way whose availMask bit is 1 and whose lockBits bit is 0.
- R2: The victim is the first free way found scanning upward from the round-robin pointer with wrap-around. The pointer resets to 0 and, after every miss, moves to the way after the victim (way NUM_WAYS-1 wraps to 0).
- R3: A granted lock request (reqLock=1) sets, in the same cycle, the lockNext bit of the target way and asserts lockWe. The target is hitWay on a hit (reqMiss=0) and victimWay on a miss.
- R4: A lock request that would leave no way with availMask=1 and lockNext=0 is refused. lockNext keeps the target's bit unchanged, victimWay is unaffected, and lockErrFlag reads 1 from the next cycle.
- R5: On a miss with an empty free set and a non-zero mask, victimWay is the lowest-numbered way whose availMask bit is 1. Its bit is cleared in lockNext, lockWe is 1, and noVictimFlag reads 1 from the next cycle.
- R6: Both flags are 0 after reset and stay set until the matching clear input (clrLockErr, clrNoVictim) is 1 at a clock edge. A new event in the same cycle as a clear keeps the flag set.
- R7: lockErrIrq is lockErrFlag AND lockIrqEn; noVictimIrq is noVictimFlag AND noVictimIrqEn, each independent of the other.
- R8: With reqValid=0, lockWe is 0 and neither the flags nor the round-robin pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is presented this cycle |
| reqMiss | input | 1 | 1 = miss (fill a victim), 0 = hit |
| reqLock | input | 1 | Lock the accessed line |
| hitWay | input | 3 | Way holding the line on a hit |
| lockBits | input | 8 | Current lock bits at the index |
| availMask | input | 8 | Ways the requester may use |
| lockIrqEn | input | 1 | Interrupt enable for the lock-refused flag |
| noVictimIrqEn | input | 1 | Interrupt enable for the no-victim flag |
| clrLockErr | input | 1 | Write-1 clear of the lock-refused flag |
| clrNoVictim | input | 1 | Write-1 clear of the no-victim flag |
| victimWay | output | 3 | Chosen victim way |
| lockWe | output | 1 | Write strobe for lockNext |
| lockNext | output | 8 | Updated lock bits for the index |
| lockErrFlag | output | 1 | Sticky lock-refused flag |
| noVictimFlag | output | 1 | Sticky no-victim flag |
| lockErrIrq | output | 1 | Lock-refused interrupt |
| noVictimIrq | output | 1 | No-victim interrupt |

## Verification
The bench drives the round-robin scan across locked ways and ways outside the mask, and through the wrap from the top way to way 0. A design with a faulty scan would return a locked or masked-off way, or would repeat the same way after a wrap. It locks the last free way both on a hit and on a miss fill; a design that skips the check would lock every usable way and set no flag. It forces the no-victim fallback, where a wrong design would pick a locked way that is not the lowest, or would leave its lock set. It also asserts a flag clear in the same cycle as a new event, where a design that gives the clear priority would lose the event.

// File: rtl/wvl_pkg.sv
package wvl_pkg;
  // Strobes from control to datapath for the current request
  typedef struct packed {
    logic fill;     // a miss: choose and fill a victim
    logic lockReq;  // lock the target line
  } wvl_cmd_t;

  // Events reported back from datapath to control
  typedef struct packed {
    logic noVictim;    // miss found no free way
    logic lockRefused; // lock would have taken the last free way
  } wvl_evt_t;
endpackage

// File: rtl/wvl_datapath.sv
module wvl_datapath
  import wvl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  wvl_cmd_t            cmd,
  input  logic [WAY_W-1:0]    hitWay,
  input  logic [NUM_WAYS-1:0] lockBits,
  input  logic [NUM_WAYS-1:0] availMask,
  input  logic [WAY_W-1:0]    rrPtr,
  output logic [WAY_W-1:0]    victimWay,
  output logic                lockWe,
  output logic [NUM_WAYS-1:0] lockNext,
  output wvl_evt_t            evt
);
  logic [NUM_WAYS-1:0] freeWays, victimOh, targetOh, afterFill, remaining;
  logic [WAY_W-1:0]    rrWay, lowWay, targetWay;
  logic                rrFound, fallback, grant;

  assign freeWays = availMask & ~lockBits;

  // Round-robin scan from the pointer, wrapping past the top way
  always_comb begin
    rrFound = 1'b0;
    rrWay   = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      int idx;
      idx = (int'(rrPtr) + k) % NUM_WAYS;
      if (!rrFound && freeWays[idx]) begin
        rrFound = 1'b1;
        rrWay   = WAY_W'(idx);
      end
    end
  end

  // Lowest way in the mask, used when nothing is free
  always_comb begin
    lowWay = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (availMask[i]) lowWay = WAY_W'(i);
    end
  end

  always_comb begin
    fallback  = ~rrFound;
    victimWay = fallback ? lowWay : rrWay;
    victimOh  = NUM_WAYS'(1) << victimWay;
    afterFill = (cmd.fill && fallback) ? (lockBits & ~victimOh) : lockBits;
    targetWay = cmd.fill ? victimWay : hitWay;
    targetOh  = NUM_WAYS'(1) << targetWay;
    remaining = availMask & ~afterFill & ~targetOh;
    grant     = cmd.lockReq && (|remaining);
    lockNext  = afterFill | (grant ? targetOh : '0);
    lockWe    = (cmd.fill && fallback) || grant;
    evt.noVictim    = cmd.fill && fallback;
    evt.lockRefused = cmd.lockReq && !grant;
  end
endmodule

// File: rtl/wvl_ctrl.sv
module wvl_ctrl
  import wvl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqMiss,
  input  logic             reqLock,
  input  logic [WAY_W-1:0] victimWay,
  input  wvl_evt_t         evt,
  input  logic             lockIrqEn,
  input  logic             noVictimIrqEn,
  input  logic             clrLockErr,
  input  logic             clrNoVictim,
  output wvl_cmd_t         cmd,
  output logic [WAY_W-1:0] rrPtr,
  output logic             lockErrFlag,
  output logic             noVictimFlag,
  output logic             lockErrIrq,
  output logic             noVictimIrq
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

  assign cmd.fill    = reqValid && reqMiss;
  assign cmd.lockReq = reqValid && reqLock;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rrPtr        <= '0;
      lockErrFlag  <= 1'b0;
      noVictimFlag <= 1'b0;
    end else begin
      if (cmd.fill) rrPtr <= (victimWay == LAST_WAY) ? '0 : victimWay + 1'b1;
      // a new event outranks a clear in the same cycle
      if (evt.lockRefused)  lockErrFlag  <= 1'b1;
      else if (clrLockErr)  lockErrFlag  <= 1'b0;
      if (evt.noVictim)     noVictimFlag <= 1'b1;
      else if (clrNoVictim) noVictimFlag <= 1'b0;
    end
  end

  assign lockErrIrq  = lockErrFlag && lockIrqEn;
  assign noVictimIrq = noVictimFlag && noVictimIrqEn;
endmodule

// File: rtl/way_victim_lock_sel.sv
module way_victim_lock_sel
  import wvl_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqMiss,
  input  logic                reqLock,
  input  logic [WAY_W-1:0]    hitWay,
  input  logic [NUM_WAYS-1:0] lockBits,
  input  logic [NUM_WAYS-1:0] availMask,
  input  logic                lockIrqEn,
  input  logic                noVictimIrqEn,
  input  logic                clrLockErr,
  input  logic                clrNoVictim,
  output logic [WAY_W-1:0]    victimWay,
  output logic                lockWe,
  output logic [NUM_WAYS-1:0] lockNext,
  output logic                lockErrFlag,
  output logic                noVictimFlag,
  output logic                lockErrIrq,
  output logic                noVictimIrq
);
  wvl_cmd_t         cmd;
  wvl_evt_t         evt;
  logic [WAY_W-1:0] rrPtr;

  wvl_ctrl #(.NUM_WAYS(NUM_WAYS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMiss(reqMiss),
    .reqLock(reqLock), .victimWay(victimWay), .evt(evt),
    .lockIrqEn(lockIrqEn), .noVictimIrqEn(noVictimIrqEn),
    .clrLockErr(clrLockErr), .clrNoVictim(clrNoVictim),
    .cmd(cmd), .rrPtr(rrPtr), .lockErrFlag(lockErrFlag),
    .noVictimFlag(noVictimFlag), .lockErrIrq(lockErrIrq),
    .noVictimIrq(noVictimIrq)
  );

  wvl_datapath #(.NUM_WAYS(NUM_WAYS)) u_dp (
    .cmd(cmd), .hitWay(hitWay), .lockBits(lockBits), .availMask(availMask),
    .rrPtr(rrPtr), .victimWay(victimWay), .lockWe(lockWe),
    .lockNext(lockNext), .evt(evt)
  );
endmodule

// File: rtl/wvl_checker.sv
module wvl_checker #(
  parameter int NUM_WAYS = 8,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqMiss,
  input logic                reqLock,
  input logic [WAY_W-1:0]    hitWay,
  input logic [NUM_WAYS-1:0] lockBits,
  input logic [NUM_WAYS-1:0] availMask,
  input logic                clrLockErr,
  input logic                clrNoVictim,
  input logic                noVictimIrqEn,
  input logic [WAY_W-1:0]    victimWay,
  input logic                lockWe,
  input logic [NUM_WAYS-1:0] lockNext,
  input logic                lockErrFlag,
  input logic                noVictimFlag,
  input logic                noVictimIrq
);
  logic [NUM_WAYS-1:0] freeNow, hitOh, belowVictim;
  assign freeNow     = availMask & ~lockBits;
  assign hitOh       = NUM_WAYS'(1) << hitWay;
  assign belowVictim = (NUM_WAYS'(1) << victimWay) - NUM_WAYS'(1);

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMiss && (|freeNow)) |-> (availMask[victimWay] && !lockBits[victimWay])); // R1

  AST_HIT_LOCK_SET: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqMiss && reqLock && (|(freeNow & ~hitOh))) |-> (lockWe && lockNext[hitWay])); // R3

  AST_KEEP_ONE_FREE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqLock && (|freeNow)) |-> (|(availMask & ~lockNext))); // R4

  AST_FALLBACK_LOWEST: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMiss && (|availMask) && !(|freeNow))
      |-> (availMask[victimWay] && ((availMask & belowVictim) == '0) && !lockNext[victimWay] && lockWe)); // R5

  AST_NOVICTIM_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMiss && (|availMask) && !(|freeNow)) |=> noVictimFlag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lockErrFlag && !clrLockErr) |=> lockErrFlag); // R6

  AST_NOVICTIM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (noVictimFlag && !clrNoVictim) |=> noVictimFlag); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!noVictimIrqEn || !noVictimFlag) |-> !noVictimIrq); // R7

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !lockWe); // R8
endmodule

bind way_victim_lock_sel wvl_checker #(.NUM_WAYS(NUM_WAYS)) u_wvl_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMiss(reqMiss),
  .reqLock(reqLock), .hitWay(hitWay), .lockBits(lockBits),
  .availMask(availMask), .clrLockErr(clrLockErr), .clrNoVictim(clrNoVictim),
  .noVictimIrqEn(noVictimIrqEn), .victimWay(victimWay), .lockWe(lockWe),
  .lockNext(lockNext), .lockErrFlag(lockErrFlag),
  .noVictimFlag(noVictimFlag), .noVictimIrq(noVictimIrq)
);

// File: tb/tb_way_victim_lock_sel.sv
module tb_way_victim_lock_sel;
  localparam int CLK_P = 10;
  localparam int NV = 9;
  // {miss, lock, hitWay[2:0], lockBits[7:0], mask[7:0], expVictim[2:0], expWe, expNext[7:0]}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 3'd0, 1'b0, 8'h00},  // R1 R2 ptr 0
    {1'b1, 1'b0, 3'd0, 8'h02, 8'hFF, 3'd2, 1'b0, 8'h02},  // R2 skip locked way 1
    {1'b1, 1'b0, 3'd0, 8'h00, 8'h03, 3'd0, 1'b0, 8'h00},  // R2 wrap to way 0
    {1'b1, 1'b1, 3'd0, 8'h00, 8'hF0, 3'd4, 1'b1, 8'h10},  // R3 fill and lock
    {1'b0, 1'b1, 3'd6, 8'h00, 8'hFF, 3'd0, 1'b1, 8'h40},  // R3 hit lock
    {1'b1, 1'b0, 3'd0, 8'h20, 8'hFF, 3'd6, 1'b0, 8'h20},  // R1 skip locked 5
    {1'b1, 1'b0, 3'd0, 8'h80, 8'hC0, 3'd6, 1'b0, 8'h80},  // R1 mask limits
    {1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 3'd7, 1'b0, 8'h00},  // R2 top way
    {1'b1, 1'b0, 3'd0, 8'h00, 8'hFF, 3'd0, 1'b0, 8'h00}   // R2 pointer wrapped
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqMiss = 0, reqLock = 0;
  logic [2:0] hitWay = '0;
  logic [7:0] lockBits = '0, availMask = '0;
  logic lockIrqEn = 0, noVictimIrqEn = 0, clrLockErr = 0, clrNoVictim = 0;
  logic [2:0] victimWay;
  logic lockWe, lockErrFlag, noVictimFlag, lockErrIrq, noVictimIrq;
  logic [7:0] lockNext;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  way_victim_lock_sel dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic m, input logic l, input logic [2:0] h,
                       input logic [7:0] lb, input logic [7:0] mk);
    @(negedge clk);
    reqValid = v; reqMiss = m; reqLock = l; hitWay = h; lockBits = lb; availMask = mk;
    #(CLK_P/4);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; reqMiss = 0; reqLock = 0; clrLockErr = 0; clrNoVictim = 0;
    #(CLK_P/4);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #(CLK_P/4);
    chk("R6 reset lockErrFlag", 32'(lockErrFlag), 0);
    chk("R6 reset noVictimFlag", 32'(noVictimFlag), 0);
    chk("R8 idle lockWe", 32'(lockWe), 0);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = VEC[i];
      drive(1'b1, v[32], v[31], v[30:28], v[27:20], v[19:12]);
      if (v[32]) chk($sformatf("R1 R2 vec%0d victim", i), 32'(victimWay), 32'(v[11:9]));
      chk($sformatf("R3 vec%0d lockWe", i), 32'(lockWe), 32'(v[8]));
      chk($sformatf("R3 vec%0d lockNext", i), 32'(lockNext), 32'(v[7:0]));
    end
    idle();
    chk("R8 no flags after clean table", 32'({lockErrFlag, noVictimFlag}), 0);

    // R4: hit lock on last free way (mask 0b011, way 1 locked)
    drive(1'b1, 1'b0, 1'b1, 3'd0, 8'h02, 8'h03);
    chk("R4 refused lockWe", 32'(lockWe), 0);
    chk("R4 refused lockNext", 32'(lockNext), 32'h02);
    idle();
    chk("R4 lockErrFlag set", 32'(lockErrFlag), 1);
    chk("R7 lockErrIrq masked", 32'(lockErrIrq), 0);
    lockIrqEn = 1; #1;
    chk("R7 lockErrIrq enabled", 32'(lockErrIrq), 1);
    chk("R7 noVictimIrq independent", 32'(noVictimIrq), 0);

    // R8: idle with miss data present changes nothing
    @(negedge clk);
    reqValid = 0; reqMiss = 1; reqLock = 1; lockBits = 8'h00; availMask = 8'hFF;
    #(CLK_P/4);
    chk("R8 idle lockWe", 32'(lockWe), 0);
    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'h00, 8'hFF);
    chk("R8 pointer held, R6 flag held", 32'({victimWay, lockErrFlag}), 32'({3'd1, 1'b1}));

    // R6: clear
    @(negedge clk);
    reqValid = 0; clrLockErr = 1;
    idle();
    chk("R6 lockErrFlag cleared", 32'(lockErrFlag), 0);
    chk("R7 lockErrIrq follows flag", 32'(lockErrIrq), 0);

    // R5: fallback, all available ways locked (mask 0x0C)
    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'h0C, 8'h0C);
    chk("R5 fallback victim", 32'(victimWay), 2);
    chk("R5 fallback lockWe", 32'(lockWe), 1);
    chk("R5 fallback lockNext", 32'(lockNext), 32'h08);
    idle();
    chk("R5 noVictimFlag set", 32'(noVictimFlag), 1);
    chk("R5 lockErrFlag untouched", 32'(lockErrFlag), 0);

    // R6: event and clear in the same cycle
    drive(1'b1, 1'b1, 1'b0, 3'd0, 8'h0C, 8'h0C);
    clrNoVictim = 1;
    idle();
    chk("R6 set wins over clear", 32'(noVictimFlag), 1);
    chk("R7 noVictimIrq masked", 32'(noVictimIrq), 0);
    noVictimIrqEn = 1; #1;
    chk("R7 noVictimIrq enabled", 32'(noVictimIrq), 1);
    @(negedge clk);
    clrNoVictim = 1;
    idle();
    chk("R6 noVictimFlag cleared", 32'(noVictimFlag), 0);

    // R4: miss with lock on last free way; fill still proceeds
    drive(1'b1, 1'b1, 1'b1, 3'd0, 8'h02, 8'h03);
    chk("R4 miss victim unaffected", 32'(victimWay), 0);
    chk("R4 miss refused lockWe", 32'(lockWe), 0);
    chk("R4 miss refused lockNext", 32'(lockNext), 32'h02);
    idle();
    chk("R4 miss lockErrFlag set", 32'(lockErrFlag), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule